// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block handles a stop request for an I2C master port. Software writes a request through a register-write strobe. The block decides from the port's status whether the request is legal. A legal request arms a sequencer, which drives the SDA and SCL open-drain pull enables to place a stop condition on the bus. The setup delay is programmable.

Byte shifting, start generation, address matching and arbitration detection are handled elsewhere and reach this block only as status inputs. These inputs are:
- master/slave state;
- transmit or receive direction;
- acknowledge-generation enable;
- the wait after the 8th clock and the wait after the 9th clock;
- the chosen wait point;
- transfer-in-progress.

The pending request is cleared by any of these events: a stop seen on the bus, arbitration loss, a communication-release command, the port being disabled, or reset. SCL and SDA are resynchronized before the block samples them. A slave that stretches SCL holds the sequence until SCL is seen high.

Top module: `i2c_stop_ctrl`

## Requirements
- R1: A stop write is accepted only when `is_master` is 1. In slave or idle state the write leaves `stop_pend`, `sda_pull` and `scl_pull` unchanged.
- R2: A write with both `wr_stop` and `wr_start` at 1 is rejected.
- R3: While a request is pending, further stop writes have no effect. The sequence timing is unchanged by them.
- R4: A stop write is rejected while `xfer_busy` is 1.
- R5: When transmitting (`xmit`=1), a stop write is accepted only while `in_wait9` is 1. The wait after the 8th clock is the ACK reception period and is rejected.
- R6: When receiving (`xmit`=0), a stop write is accepted only if `ack_gen` is 0 and one of the following holds:
  - `in_wait9` is 1;
  - `in_wait8` is 1 with 8th-clock wait mode (`wait_on9`=0).
  In that second case the stop is produced during the high phase of the 9th clock.
- R7: On the clock edge that accepts a write, both pull enables go to 1, where 1 means drive the line low. `scl_pull` returns to 0 setup_cyc+1 edges later.
- R8: After SCL is released, the sequence waits until the synchronized SCL is high. Stretching SCL by N cycles delays every later event by N cycles.
- R9: After SCL is sampled high, the block counts setup_cyc further cycles and then releases SDA, so SDA rises while SCL is high. `sda_pull` falls 2·setup_cyc+5 edges after acceptance, and `stop_seen` pulses 2·setup_cyc+7 edges after acceptance.
- R10: A detected stop, meaning synchronized SDA rising while synchronized SCL is high, clears the request on the next edge. Without stretching this is edge 2·setup_cyc+8.
- R11: Arbitration loss, communication release, or `en`=0 clears the request and releases both lines on the next edge. With `en`=0 no write is accepted.
- R12: `stop_pend` reads 0 in the cycle right after the accepting edge and reads 1 from the following cycle while the request stays pending.
- R13: After reset, `stop_pend`, `sda_pull`, `scl_pull` and `stop_seen` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Port operation enable |
| wr_stb | input | 1 | Control-register write strobe |
| wr_stop | input | 1 | Stop-request bit of the written data |
| wr_start | input | 1 | Start-request bit of the written data |
| is_master | input | 1 | Port currently owns the bus as master |
| xmit | input | 1 | 1 = transmitting, 0 = receiving |
| ack_gen | input | 1 | Acknowledge generation enabled |
| in_wait8 | input | 1 | Port is in the wait after the 8th clock |
| in_wait9 | input | 1 | Port is in the wait after the 9th clock |
| wait_on9 | input | 1 | Wait-point mode: 1 = after 9th clock, 0 = after 8th |
| xfer_busy | input | 1 | Byte transfer in progress |
| arb_lost | input | 1 | Arbitration-loss event |
| comm_rel | input | 1 | Communication-release command |
| setup_cyc | input | CNT_W | SDA-low hold and stop setup count, in clock cycles |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 = drive SCL low |
| sda_pull | output | 1 | 1 = drive SDA low |
| stop_pend | output | 1 | Readback of the pending stop request |
| stop_seen | output | 1 | One-cycle pulse on a detected stop condition |

## Verification
Each result has a fixed latency in clock edges from the edge that takes the write:
- the pull enables rise on that edge;
- the readback shows 0 after it and 1 one edge later;
- SCL is released after setup_cyc+1 edges;
- SDA is released after 2·setup_cyc+5 edges, plus any stretch;
- the stop pulse appears after 2·setup_cyc+7 edges;
- the request clears after 2·setup_cyc+8 edges;
- a clearing event acts on the next edge.

The bench counts edges from the accepting edge and samples every output on the falling clock edge. Each measured delay is compared with these formulas. The legality rules are checked by sweeping all 512 combinations of the status inputs and the start bit, with the expected outcome computed from the requirement formulas.

// File: rtl/i2c_stop_pkg.sv
`timescale 1ns/1ps
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_HOLD   = 3'd1,
    SQ_SCLREL = 3'd2,
    SQ_SETUP  = 3'd3,
    SQ_SDAREL = 3'd4
  } sq_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] line_sync,
  output logic [LINES-1:0] line_prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb chain_d = {chain_q[DEPTH-2:0], line_in[g]};

    // idle bus level is high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign line_sync[g] = chain_q[STAGES-1];
    assign line_prev[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/i2c_stop_gate.sv
`timescale 1ns/1ps
module i2c_stop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr_stb,
  input  logic wr_stop,
  input  logic wr_start,
  input  logic is_master,
  input  logic xmit,
  input  logic ack_gen,
  input  logic in_wait8,
  input  logic in_wait9,
  input  logic wait_on9,
  input  logic xfer_busy,
  input  logic arb_lost,
  input  logic comm_rel,
  input  logic stop_seen,
  output logic accept,
  output logic kill,
  output logic req,
  output logic rd
);
  logic legal_pt;
  logic req_q, req_d, req_en;
  logic fresh_q, fresh_d;

  always_comb begin
    // transmitter: only after the 9th clock; receiver: NACK mode only
    if (xmit) legal_pt = in_wait9;
    else      legal_pt = !ack_gen && (in_wait9 || (in_wait8 && !wait_on9));
    kill   = !en || arb_lost || comm_rel;
    accept = wr_stb && wr_stop && !wr_start && en && is_master &&
             !xfer_busy && !req_q && legal_pt && !kill && !stop_seen;
    req_d = req_q;
    if (accept)             req_d = 1'b1;
    if (kill || stop_seen)  req_d = 1'b0;
    req_en  = accept || kill || stop_seen;
    fresh_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b0;
    else        fresh_q <= fresh_d;
  end

  assign req = req_q;
  assign rd  = req_q && !fresh_q;

  assert_set_master_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(is_master && wr_stb && wr_stop));
  assert_no_start_with_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(wr_start));
  assert_hold_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && en && !arb_lost && !comm_rel && !stop_seen) |=> req_q);
  assert_idle_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(xfer_busy));
  assert_tx_after_ninth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && $past(xmit)) |-> $past(in_wait9));
  assert_rx_nack_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && !$past(xmit)) |-> !$past(ack_gen));
  assert_clear_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !req_q);
  assert_clear_events_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || arb_lost || comm_rel) |=> !req_q);
  assert_readback_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !rd);
endmodule

// File: rtl/i2c_stop_seq.sv
`timescale 1ns/1ps
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic             stop_seen,
  input  logic             scl_s,
  input  logic [CNT_W-1:0] setup_cyc,
  output logic             scl_pull,
  output logic             sda_pull
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  sq_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        state_d = SQ_HOLD;
        cnt_d   = setup_cyc;
        cnt_en  = 1'b1;
      end
      SQ_HOLD: begin
        if (cnt_q == '0) state_d = SQ_SCLREL;
        else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      SQ_SCLREL: if (scl_s) begin
        state_d = SQ_SETUP;
        cnt_d   = setup_cyc;
        cnt_en  = 1'b1;
      end
      SQ_SETUP: begin
        if (!scl_s)            state_d = SQ_SCLREL;
        else if (cnt_q == '0)  state_d = SQ_SDAREL;
        else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      SQ_SDAREL: ;
      default: state_d = SQ_IDLE;
    endcase
    if (kill || stop_seen) state_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign scl_pull = (state_q == SQ_HOLD);
  assign sda_pull = (state_q == SQ_HOLD) || (state_q == SQ_SCLREL) ||
                    (state_q == SQ_SETUP);

  assert_hold_countdown_R7: assert property (@(posedge clk)
    disable iff (!rst_n || kill || stop_seen)
    (state_q == SQ_HOLD && cnt_q != '0) |=>
      (state_q == SQ_HOLD && cnt_q == $past(cnt_q) - CNT_ONE));
  assert_wait_scl_high_R8: assert property (@(posedge clk)
    disable iff (!rst_n || kill || stop_seen)
    (state_q == SQ_SCLREL && !scl_s) |=> (state_q == SQ_SCLREL));
  assert_sda_rise_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && !$past(kill) && !$past(stop_seen)) |-> $past(scl_s));
endmodule

// File: rtl/i2c_stop_ctrl.sv
`timescale 1ns/1ps
module i2c_stop_ctrl #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_stb,
  input  logic             wr_stop,
  input  logic             wr_start,
  input  logic             is_master,
  input  logic             xmit,
  input  logic             ack_gen,
  input  logic             in_wait8,
  input  logic             in_wait9,
  input  logic             wait_on9,
  input  logic             xfer_busy,
  input  logic             arb_lost,
  input  logic             comm_rel,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             stop_pend,
  output logic             stop_seen
);
  localparam int unsigned LINES = 2;
  localparam int unsigned SCL_I = 0;
  localparam int unsigned SDA_I = 1;

  logic [1:0]       rst_pipe;
  logic             rst_n_i;
  logic [LINES-1:0] ln_sync, ln_prev;
  logic             accept, kill, req;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .line_in   ({sda_in, scl_in}),
    .line_sync (ln_sync),
    .line_prev (ln_prev)
  );

  assign stop_seen = ln_sync[SCL_I] && ln_prev[SCL_I] &&
                     ln_sync[SDA_I] && !ln_prev[SDA_I];

  i2c_stop_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (en),
    .wr_stb    (wr_stb),
    .wr_stop   (wr_stop),
    .wr_start  (wr_start),
    .is_master (is_master),
    .xmit      (xmit),
    .ack_gen   (ack_gen),
    .in_wait8  (in_wait8),
    .in_wait9  (in_wait9),
    .wait_on9  (wait_on9),
    .xfer_busy (xfer_busy),
    .arb_lost  (arb_lost),
    .comm_rel  (comm_rel),
    .stop_seen (stop_seen),
    .accept    (accept),
    .kill      (kill),
    .req       (req),
    .rd        (stop_pend)
  );

  i2c_stop_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (accept),
    .kill      (kill),
    .stop_seen (stop_seen),
    .scl_s     (ln_sync[SCL_I]),
    .setup_cyc (setup_cyc),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull)
  );

  assert_lines_follow_request_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    sda_pull |-> req);
endmodule

// File: tb/tb_i2c_stop_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_stop_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic en, wr_stb, wr_stop, wr_start, is_master, xmit, ack_gen;
  logic in_wait8, in_wait9, wait_on9, xfer_busy, arb_lost, comm_rel;
  logic [15:0] setup_cyc;
  logic scl_in, sda_in, scl_pull, sda_pull, stop_pend, stop_seen;
  logic stretch;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = ~scl_pull & ~stretch;
  assign sda_in = ~sda_pull;

  i2c_stop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_stb(wr_stb), .wr_stop(wr_stop),
    .wr_start(wr_start), .is_master(is_master), .xmit(xmit), .ack_gen(ack_gen),
    .in_wait8(in_wait8), .in_wait9(in_wait9), .wait_on9(wait_on9),
    .xfer_busy(xfer_busy), .arb_lost(arb_lost), .comm_rel(comm_rel),
    .setup_cyc(setup_cyc), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .stop_pend(stop_pend),
    .stop_seen(stop_seen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_legal();
    en = 1; is_master = 1; xmit = 1; ack_gen = 1; in_wait8 = 0; in_wait9 = 1;
    wait_on9 = 1; xfer_busy = 0; arb_lost = 0; comm_rel = 0; wr_start = 0;
    wr_stop = 1; wr_stb = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_stop(input int s, input int t, input bit dup, input bit rx8);
    int e0, rel;
    int t_scl = -1, t_sda = -1, t_det = -1, t_clr = -1;
    set_legal();
    if (rx8) begin xmit = 0; ack_gen = 0; in_wait8 = 1; in_wait9 = 0; wait_on9 = 0; end
    setup_cyc = 16'(s);
    stretch = (t > 0);
    @(negedge clk);
    wr_stb = 1;
    e0 = cyc + 1;
    for (int k = 0; k < 2*s + t + 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      rel = cyc - e0;
      wr_stb = dup && (rel == 1);
      if (rel == 0) begin
        chk("R7 both lines pulled on accepting edge", {30'd0, scl_pull, sda_pull}, 3);
        chk("R12 readback right after set", stop_pend, 0);
      end
      if (rel == 1) chk("R12 readback one cycle later", stop_pend, 1);
      if (t_scl < 0 && !scl_pull) t_scl = rel;
      if (t_scl >= 0 && stretch && rel - t_scl >= t) stretch = 0;
      if (t_sda < 0 && !sda_pull) t_sda = rel;
      if (t_det < 0 && stop_seen) t_det = rel;
      if (t_clr < 0 && rel > 1 && !stop_pend) t_clr = rel;
    end
    chk("R7 scl release edge", t_scl, s + 1);
    if (t > 0) chk("R8 sda release delayed by stretch", t_sda, 2*s + 5 + t);
    else if (dup) chk("R3 repeated write leaves timing", t_sda, 2*s + 5);
    else if (rx8) chk("R6 eighth-clock wait stop in ninth clock high", t_sda, 2*s + 5);
    else chk("R9 sda release edge", t_sda, 2*s + 5);
    chk("R9 stop detect edge", t_det, 2*s + 7 + t);
    chk("R10 request cleared by detected stop", t_clr, 2*s + 8 + t);
    stretch = 0;
    wr_stb = 0;
    idle(4);
  endtask

  task automatic run_kill(input int kind);
    set_legal();
    setup_cyc = 16'd6;
    @(negedge clk); wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    @(negedge clk);
    case (kind)
      0: arb_lost = 1;
      1: comm_rel = 1;
      default: en = 0;
    endcase
    @(negedge clk);
    chk("R11 lines released after clear event", {30'd0, scl_pull, sda_pull}, 0);
    chk("R11 request cleared after clear event", stop_pend, 0);
    arb_lost = 0; comm_rel = 0; en = 1;
    idle(6);
  endtask

  function automatic string sweep_tag(input int v);
    if (!v[0]) return "R11 disabled port write";
    if (!v[1]) return "R1 write outside master mode";
    if (v[8])  return "R2 start and stop together";
    if (v[7])  return "R4 write during transfer";
    if (v[2])  return "R5 transmit wait point";
    return "R6 receive wait point";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_legal();
    setup_cyc = 16'd0;
    stretch = 0;
    rst_n = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R13 reset scl_pull", scl_pull, 0);
    chk("R13 reset sda_pull", sda_pull, 0);
    chk("R13 reset stop_pend", stop_pend, 0);
    chk("R13 reset stop_seen", stop_seen, 0);
    rst_n = 1;
    idle(5);

    // legality sweep over all status combinations
    for (int v = 0; v < 512; v++) begin
      bit ex;
      set_legal();
      setup_cyc = 16'd4;
      en = v[0]; is_master = v[1]; xmit = v[2]; ack_gen = v[3];
      in_wait8 = v[4]; in_wait9 = v[5]; wait_on9 = v[6]; xfer_busy = v[7];
      wr_start = v[8];
      ex = v[0] && v[1] && !v[8] && !v[7] &&
           (v[2] ? v[5] : (!v[3] && (v[5] || (v[4] && !v[6]))));
      wr_stb = 1;
      @(negedge clk);
      wr_stb = 0;
      chk(sweep_tag(v), sda_pull, int'(ex));
      @(negedge clk);
      chk(sweep_tag(v), stop_pend, int'(ex));
      en = 1;
      comm_rel = 1;
      @(negedge clk);
      comm_rel = 0;
      idle(6);
    end

    // sequence timing across setup counts
    run_stop(0, 0, 0, 0);
    run_stop(1, 0, 0, 0);
    run_stop(2, 0, 0, 0);
    run_stop(5, 0, 0, 0);
    run_stop(13, 0, 0, 0);
    run_stop(3, 0, 1, 0);
    run_stop(4, 0, 0, 1);
    run_stop(2, 3, 0, 0);
    run_stop(0, 7, 0, 0);
    run_kill(0);
    run_kill(1);
    run_kill(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule